// File: doc/BRIEF.md
# Four-Channel PWM with Shared Period Counter and Sticky Compare

This block drives four pulse-width-modulated pins from one free-running period counter. Every channel owns a 16-bit compare register. A channel's internal "hit" flag is set while the scaled counter value is at or above that channel's compare value. Each pin carries the inverse of its hit flag, so only inverted polarity is available. Because all four channels look at the same counter, the period length is the same for all of them. A prescale field sets the period by choosing which 16-bit window of a wider counter is compared.

Software programs the block through a plain write port. One address holds the configuration: run, sticky-compare mode and prescale. Four further addresses hold the compare values. Compare writes act at once, with no shadow copy, so a period that spans a write can mix old and new settings. The sticky-compare mode keeps a hit flag high until the scaled counter wraps to zero. This lets a compare value be rewritten in mid-period without producing an early edge on the pin.

Top module: `pwm_shared_ctr`

## Requirements
- R1: After reset the counter is zero, run and sticky mode are clear, the prescale is zero, all compare registers are zero, all hit flags are low and all four pins are high.
- R2: While run (configuration bit 5) is set, the counter advances by one per clock. While run is clear, the counter and all pins hold their values.
- R3: On each clock with run set, hit flag i is updated from the scaled value S and compare i taken before that edge. It goes high when S >= compare i. Pin i is the inverse of hit flag i.
- R4: A compare value written on one clock edge is reflected on its pin after the next edge, so it is visible one cycle after the register updates.
- R5: With sticky mode clear, raising a compare value above S drops that hit flag on the next edge, and the pin rises.
- R6: With sticky mode (configuration bit 4) set, a high hit flag stays high while S is non-zero. It is re-evaluated only while S is zero, that is, after the counter wraps.
- R7: The prescale field (configuration bits 3:0, value k) selects S as counter bits [k+15:k]. S therefore advances once every 2^k clocks.
- R8: All channels compare against the same S. A compare value of 0 holds the pin low at every step. A compare value of 0xFFFF gives the pin its longest high time, low only while S is 0xFFFF, so no setting keeps the pin high for a whole period.
- R9: Address 0 is the configuration register and addresses 1 to 4 are compare 0 to 3. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 config, 1..4 compare 0..3) |
| wr_data | input | 16 | Write data |
| pwm_n | output | 4 | Inverted PWM pins, one per channel |

## Verification
Several rules are checked on every cycle against the live design: the counter steps or freezes according to run, a stopped block freezes its pins, sticky flags never fall while S is non-zero, the non-sticky flag follows the compare, a zero compare forces the flag high, and writes to unmapped addresses leave every register alone. Other behaviours can only be shown by the bench's scenarios, because they need a specific sequence of events and a check on the pins. These are the reset pin levels, the one-cycle visibility of a compare write, the mid-period fall without sticky mode, the release of a sticky flag after a full 65536-step wrap, and the slower stepping under a non-zero prescale.

// File: rtl/pwm_shared_pkg.sv
package pwm_shared_pkg;
   localparam int SCALE_BITS = 4;
   localparam int CFG_DGL_BIT = 4;
   localparam int CFG_RUN_BIT = 5;

   typedef struct packed {
      logic                  run;
      logic                  sticky;
      logic [SCALE_BITS-1:0] scale;
   } pwm_cfg_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import pwm_shared_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int CMP_W  = 16,
   parameter int ADDR_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [CMP_W-1:0]            wr_data,
   output pwm_cfg_t                    cfg,
   output logic [NCH-1:0][CMP_W-1:0]   cmp
);
   localparam logic [ADDR_W-1:0] CFG_ADDR = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en && wr_addr == CFG_ADDR) begin
         cfg.run    <= wr_data[CFG_RUN_BIT];
         cfg.sticky <= wr_data[CFG_DGL_BIT];
         cfg.scale  <= wr_data[SCALE_BITS-1:0];
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_cmp
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp[i] <= '0;
         else if (wr_en && wr_addr == MY_ADDR)
            cmp[i] <= wr_data;
      end
   end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int CMP_W   = 16,
   parameter int SCALE_W = 4,
   localparam int CNT_W  = CMP_W + (1 << SCALE_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [SCALE_W-1:0] scale,
   output logic [CNT_W-1:0]   cnt,
   output logic [CMP_W-1:0]   scaled,
   output logic               period_start
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (run)
         cnt <= cnt + 1'b1;
   end

   assign scaled       = CMP_W'(cnt >> scale);
   assign period_start = (scaled == '0);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
   parameter int CMP_W        = 16,
   parameter bit HAS_DEGLITCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             sticky,
   input  logic             period_start,
   input  logic [CMP_W-1:0] scaled,
   input  logic [CMP_W-1:0] cmp,
   output logic             hit
);
   logic raw;
   logic hit_next;

   assign raw = (scaled >= cmp);

   if (HAS_DEGLITCH) begin : g_sticky
      assign hit_next = (sticky && !period_start) ? (hit | raw) : raw;
   end else begin : g_plain
      logic unused_sticky;
      assign unused_sticky = sticky ^ period_start;
      assign hit_next = raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hit <= 1'b0;
      else if (run)
         hit <= hit_next;
   end
endmodule

// File: rtl/pwm_shared_ctr.sv
module pwm_shared_ctr
   import pwm_shared_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int CMP_W        = 16,
   parameter int ADDR_W       = 3,
   parameter int SCALE_W      = 4,
   parameter bit HAS_DEGLITCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CMP_W-1:0]  wr_data,
   output logic [NCH-1:0]    pwm_n
);
   localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

   if (NCH < 1 || NCH + 1 > (1 << ADDR_W)) begin : g_bad_map
      $error("pwm_shared_ctr: NCH does not fit the address space");
   end
   if (SCALE_W != SCALE_BITS) begin : g_bad_scale
      $error("pwm_shared_ctr: SCALE_W must match the package field");
   end
   if (CMP_W < 6 || CNT_W > 64) begin : g_bad_width
      $error("pwm_shared_ctr: compare width out of range");
   end

   pwm_cfg_t                  cfg;
   logic [NCH-1:0][CMP_W-1:0] cmp;
   logic [CNT_W-1:0]          cnt;
   logic [CMP_W-1:0]          scaled;
   logic                      period_start;
   logic [NCH-1:0]            hit;
   logic                      run_q;
   logic                      sticky_q;

   assign run_q    = cfg.run;
   assign sticky_q = cfg.sticky;

   pwm_cfg_regs #(.NCH(NCH), .CMP_W(CMP_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg),
      .cmp     (cmp)
   );

   pwm_timebase #(.CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_tb (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run_q),
      .scale        (cfg.scale),
      .cnt          (cnt),
      .scaled       (scaled),
      .period_start (period_start)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pwm_channel #(.CMP_W(CMP_W), .HAS_DEGLITCH(HAS_DEGLITCH)) u_ch (
         .clk          (clk),
         .rst_n        (rst_n),
         .run          (run_q),
         .sticky       (sticky_q),
         .period_start (period_start),
         .scaled       (scaled),
         .cmp          (cmp[i]),
         .hit          (hit[i])
      );
   end

   assign pwm_n = ~hit;
endmodule

// File: rtl/pwm_shared_ctr_chk.sv
module pwm_shared_ctr_chk #(
   parameter int NCH          = 4,
   parameter int CMP_W        = 16,
   parameter int ADDR_W       = 3,
   parameter int CNT_W        = 31,
   parameter bit HAS_DEGLITCH = 1'b1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      run,
   input logic                      sticky,
   input logic                      wr_en,
   input logic [ADDR_W-1:0]         wr_addr,
   input logic [CNT_W-1:0]          cnt,
   input logic [CMP_W-1:0]          scaled,
   input logic [NCH-1:0][CMP_W-1:0] cmp,
   input logic [NCH-1:0]            hit,
   input logic [NCH-1:0]            pwm_n
);
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> cnt == CNT_W'($past(cnt) + 1'b1));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(cnt) && $stable(pwm_n)));

   a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > ADDR_W'(NCH)) |=>
         ($stable(cmp) && $stable(run) && $stable(sticky)));

   if (HAS_DEGLITCH) begin : g_sticky_chk
      a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (run && sticky && scaled != '0) |=> ((hit & $past(hit)) == $past(hit)));
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch_chk
      a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !sticky) |=> hit[i] == ($past(scaled) >= $past(cmp[i])));

      a_r8_zero_cmp: assert property (@(posedge clk) disable iff (!rst_n)
         (run && cmp[i] == '0) |=> hit[i]);
   end
endmodule

bind pwm_shared_ctr pwm_shared_ctr_chk #(
   .NCH(NCH), .CMP_W(CMP_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HAS_DEGLITCH(HAS_DEGLITCH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run_q),
   .sticky  (sticky_q),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .cnt     (cnt),
   .scaled  (scaled),
   .cmp     (cmp),
   .hit     (hit),
   .pwm_n   (pwm_n)
);

// File: tb/pwm_shared_ctr_bench.sv
module pwm_shared_ctr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  pwm_n;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    mon_on   = 1'b0;
   string mtag     = "R1";

   always #2 clk = ~clk;

   pwm_shared_ctr u_pwm_shared_ctr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_n(pwm_n)
   );

   // Reference model built from the requirements
   logic [30:0] m_cnt;
   logic [15:0] m_cmp [4];
   logic        m_run, m_dg;
   logic [3:0]  m_scale;
   logic [3:0]  m_ip;
   logic [15:0] m_s;
   logic [3:0]  m_nip;

   function automatic logic next_hit(logic run, logic dg, logic [15:0] s,
                                     logic [15:0] c, logic cur);
      logic raw;
      raw = (s >= c);
      if (!run) return cur;
      if (dg && s != 16'h0) return cur | raw;
      return raw;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = '0; m_run = 0; m_dg = 0; m_scale = '0; m_ip = '0;
         for (int i = 0; i < 4; i++) m_cmp[i] = '0;
      end else begin
         m_s = 16'(m_cnt >> m_scale);
         for (int i = 0; i < 4; i++)
            m_nip[i] = next_hit(m_run, m_dg, m_s, m_cmp[i], m_ip[i]);
         if (m_run) m_cnt = m_cnt + 1'b1;
         m_ip = m_nip;
         if (wr_en) begin
            if (wr_addr == 3'd0) begin
               m_run = wr_data[5]; m_dg = wr_data[4]; m_scale = wr_data[3:0];
            end else if (wr_addr <= 3'd4) begin
               m_cmp[wr_addr - 3'd1] = wr_data;
            end
         end
      end
   end

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && mon_on) chk(mtag, pwm_n, ~m_ip);

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [3:0] snap;
      int r;
      r = $urandom(32'h5EED);
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset pins", pwm_n, 4'hF);
      mon_on = 1'b1;

      // R3 R8: shared counter, zero and max compare
      mtag = "R3 R8";
      wr(3'd1, 16'h0010); wr(3'd2, 16'h0000); wr(3'd3, 16'hFFFF); wr(3'd4, 16'h0008);
      chk("R8 zero compare before run", pwm_n, 4'hF);
      wr(3'd0, 16'h0020);
      idle(40);
      chk("R3 R8 compare pattern", pwm_n, 4'b0100);

      // R2: stop holds pins
      mtag = "R2";
      wr(3'd0, 16'h0000);
      snap = pwm_n;
      idle(20);
      chk("R2 stopped pins hold", pwm_n, snap);

      // R9: unmapped writes ignored
      mtag = "R9";
      wr(3'd5, 16'h0020); wr(3'd6, 16'hFFFF); wr(3'd7, 16'h0030);
      idle(5);
      chk("R9 unmapped write ignored", pwm_n, snap);

      // R4 R5: non-sticky mid-period fall
      do_reset();
      mtag = "R5";
      wr(3'd2, 16'h0020);
      wr(3'd0, 16'h0020);
      idle(64);
      chk("R5 ch1 active", pwm_n, 4'b0000);
      wr(3'd2, 16'h0100);
      @(negedge clk);
      chk("R4 R5 ch1 falls one cycle after write", pwm_n, 4'b0010);

      // R6: sticky mode, then wrap release
      do_reset();
      mtag = "R6";
      wr(3'd1, 16'h0020);
      wr(3'd2, 16'h0020);
      wr(3'd0, 16'h0030);
      idle(64);
      chk("R6 both active", pwm_n[1:0], 2'b00);
      wr(3'd1, 16'h0100);
      @(negedge clk);
      chk("R6 sticky ch0 stays active", pwm_n[1:0], 2'b00);
      idle(65600);
      chk("R6 ch0 released after wrap", pwm_n[1:0], 2'b01);

      // R7: prescale by 4
      do_reset();
      mtag = "R7";
      wr(3'd1, 16'h0004);
      wr(3'd0, 16'h0022);
      idle(10);
      chk("R7 early, scaled below compare", pwm_n[0], 1'b1);
      idle(20);
      chk("R7 later, scaled past compare", pwm_n[0], 1'b0);

      // Random mix: R3 R4 R9 against the model
      mtag = "R3 R4 R9 random";
      for (int k = 0; k < 2500; k++) begin
         int sel;
         sel = $urandom_range(0, 9);
         if (sel < 5) begin
            idle($urandom_range(1, 12));
         end else if (sel == 5) begin
            wr(3'd0, {10'd0, 1'b1, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 2))});
         end else if (sel == 6) begin
            wr(3'($urandom_range(5, 7)), 16'($urandom));
         end else begin
            logic [15:0] v;
            case ($urandom_range(0, 5))
               0:       v = 16'h0000;
               1:       v = 16'hFFFF;
               default: v = 16'($urandom_range(0, 255));
            endcase
            wr(3'($urandom_range(1, 4)), v);
         end
      end
      idle(4);
      mon_on = 1'b0;
      finish_run();
   end
endmodule